// File: doc/BRIEF.md
# Triggered Capture Controller with Pre-Trigger Buffer

This block records a bus of probed signals into a circular on-chip buffer on every clock once it has been armed. While armed it watches one trigger input. When the selected trigger condition appears, recording goes on until the requested number of post-trigger samples has been stored and then stops. The stored window therefore holds a chosen amount of history from before the event and the samples that follow it.

Three configuration registers are written through a simple register-write port: the trigger mode, the window depth and the trigger position as a percentage. The position splits the depth into samples before the trigger and samples after it. After capture, a read sequencer unrolls the circular buffer from the oldest sample of the window. It returns exactly depth samples in time order on a valid/ready stream and then goes back to idle.

Top module: `trig_capture`

## Requirements
- R1: While armed, and until the last post-trigger sample is taken, the probe bus is written into the buffer on every clock. Read-out returns the window oldest first, with samples in the order they were taken.
- R2: The trigger mode register sits at address 0, bits 1:0, with this encoding: 00 fires on a rising edge of the trigger input, 01 on a falling edge, 10 while the input is high and 11 while it is low. The edge modes compare the input with its value on the previous clock.
- R3: The depth register sits at address 1. A value of 0, or any value above the buffer size 2^ADDR_W, is used as 2^ADDR_W.
- R4: The position register sits at address 2. Values above 100 are treated as 100. The post-trigger count is floor(depth*(100-position)/100), raised to 1 if that gives 0. The trigger sample is the first post-trigger sample, and the pre-trigger count is depth minus the post-trigger count.
- R5: A trigger condition is accepted only once at least the pre-trigger count of samples has been written since arming. Earlier conditions are ignored.
- R6: Read-out starts at the trigger's buffer address minus the pre-trigger count, wrapping modulo the buffer size. It delivers exactly depth samples, after which out_valid drops.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R8: An arm pulse outside the idle state has no effect. Register writes outside the idle state are ignored and do not change the configuration used by a later capture.
- R9: After synchronous reset the block is idle with out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 mode, 1 depth, 2 position) |
| cfg_wdata | input | CFG_W | Register write data |
| arm | input | 1 | Start a capture (effective only when idle) |
| probe | input | PROBE_W | Probed signal bus, sampled every clock while armed |
| trig_in | input | 1 | Trigger source signal |
| out_valid | output | 1 | Read-out sample available |
| out_ready | input | 1 | Consumer accepts the read-out sample |
| out_data | output | PROBE_W | Read-out sample |

## Verification
The checker watches the stream handshake on every cycle. This covers stalls that hold data, a read-out that never runs past the configured depth and ends right after the last accepted sample, and a buffer that is never written during read-out. It also checks that leaving the armed state only ever happens once the history requirement is met, that an arm during post-trigger recording does not disturb the sequence, and that reset returns the block to idle. The actual sample values are checked only by the bench scenarios. These cover each trigger mode, a window that wraps the buffer end, clamped depth and position, a zero-history window, a rejected re-arm and a configuration write dropped while busy. Each one shows through the exact time-ordered values that come back.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        TRG_RISE = 2'b00,
        TRG_FALL = 2'b01,
        TRG_HIGH = 2'b10,
        TRG_LOW  = 2'b11
    } trg_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_DONE,
        ST_READ
    } cap_state_e;

    localparam int unsigned PCT_FULL = 100;

    // Samples kept from the trigger onward (trigger sample included), at least one.
    function automatic int unsigned post_len(int unsigned depth, int unsigned pct);
        int unsigned p;
        int unsigned n;
        p = (pct > PCT_FULL) ? PCT_FULL : pct;
        n = (depth * (PCT_FULL - p)) / PCT_FULL;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/cap_cfg.sv
module cap_cfg
    import cap_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int ADDR_W = 5,
    localparam int DW    = ADDR_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             allow,
    output trg_mode_e        mode,
    output logic [DW-1:0]    depth,
    output logic [CFG_W-1:0] pct
);
    localparam logic [CFG_W-1:0] MAX_C = CFG_W'(1 << ADDR_W);

    logic [CFG_W-1:0] depth_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= TRG_RISE;
            depth_raw <= '0;
            pct       <= CFG_W'(50);
        end else if (we && allow) begin
            case (addr)
                2'd0:    mode      <= trg_mode_e'(wdata[1:0]);
                2'd1:    depth_raw <= wdata;
                2'd2:    pct       <= wdata;
                default: ;
            endcase
        end
    end

    assign depth = (depth_raw == '0 || depth_raw > MAX_C) ? DW'(1 << ADDR_W)
                                                          : depth_raw[DW-1:0];
endmodule

// File: rtl/cap_trig.sv
module cap_trig
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_in,
    input  trg_mode_e mode,
    output logic      hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_in;
    end

    always_comb begin
        unique case (mode)
            TRG_RISE: hit = trig_in & ~prev_q;
            TRG_FALL: hit = ~trig_in & prev_q;
            TRG_HIGH: hit = trig_in;
            TRG_LOW:  hit = ~trig_in;
        endcase
    end
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int PROBE_W = 8,
    parameter int ADDR_W  = 5,
    localparam int N      = 1 << ADDR_W
)(
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [PROBE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [PROBE_W-1:0] rdata
);
    logic [PROBE_W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import cap_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int ADDR_W  = 5,
    parameter int CFG_W   = 8
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               arm,
    input  logic [PROBE_W-1:0] probe,
    input  logic               trig_in,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PROBE_W-1:0] out_data
);
    localparam int DW = ADDR_W + 1;
    localparam logic [DW-1:0] MAX_D = DW'(1 << ADDR_W);

    cap_state_e        state_q;
    trg_mode_e         cfg_mode;
    logic [DW-1:0]     cfg_depth;
    logic [CFG_W-1:0]  cfg_pct;
    logic              hit, wr_en, fire;
    logic [DW-1:0]     post_c;
    logic [ADDR_W-1:0] wptr_q, taddr_q, raddr_q;
    logic [DW-1:0]     wcnt_q, rem_q, rcnt_q, depth_q, pre_q, post_q;

    cap_cfg #(.CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .allow(state_q == ST_IDLE), .mode(cfg_mode), .depth(cfg_depth), .pct(cfg_pct)
    );

    cap_trig u_trig (
        .clk(clk), .rst(rst), .trig_in(trig_in), .mode(cfg_mode), .hit(hit)
    );

    cap_ram #(.PROBE_W(PROBE_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wptr_q), .wdata(probe),
        .raddr(raddr_q), .rdata(out_data)
    );

    assign post_c    = DW'(post_len(int'(cfg_depth), int'(cfg_pct)));
    assign wr_en     = (state_q == ST_ARMED) || (state_q == ST_POST);
    assign fire      = (state_q == ST_ARMED) && hit && (wcnt_q >= pre_q);
    assign out_valid = (state_q == ST_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wptr_q  <= '0;
            taddr_q <= '0;
            raddr_q <= '0;
            wcnt_q  <= '0;
            rem_q   <= '0;
            rcnt_q  <= '0;
            depth_q <= '0;
            pre_q   <= '0;
            post_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (arm) begin
                    state_q <= ST_ARMED;
                    wptr_q  <= '0;
                    wcnt_q  <= '0;
                    depth_q <= cfg_depth;
                    post_q  <= post_c;
                    pre_q   <= cfg_depth - post_c;
                end
                ST_ARMED: begin
                    wptr_q <= wptr_q + 1'b1;
                    if (wcnt_q != MAX_D) wcnt_q <= wcnt_q + 1'b1;
                    if (fire) begin
                        taddr_q <= wptr_q;
                        rem_q   <= post_q - 1'b1;
                        state_q <= (post_q == DW'(1)) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: begin
                    wptr_q <= wptr_q + 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    if (rem_q == DW'(1)) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    raddr_q <= taddr_q - pre_q[ADDR_W-1:0];
                    rcnt_q  <= depth_q;
                    state_q <= ST_READ;
                end
                ST_READ: if (out_ready) begin
                    raddr_q <= raddr_q + 1'b1;
                    rcnt_q  <= rcnt_q - 1'b1;
                    if (rcnt_q == DW'(1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cap_chk.sv
module cap_chk
    import cap_pkg::*;
#(
    parameter int PW = 8,
    parameter int DW = 6
)(
    input logic          clk,
    input logic          rst,
    input cap_state_e    state,
    input logic          arm,
    input logic          wr_en,
    input logic [DW-1:0] wcnt,
    input logic [DW-1:0] pre_q,
    input logic [DW-1:0] depth_q,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_data
);
    logic [DW-1:0] hs_cnt;

    always_ff @(posedge clk) begin
        if (rst || !out_valid) hs_cnt <= '0;
        else if (out_ready)    hs_cnt <= hs_cnt + 1'b1;
    end

    p_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !wr_en);

    p_guard_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ARMED && state != ST_ARMED) |-> $past(wcnt) >= $past(pre_q));

    p_len_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> hs_cnt < depth_q);

    p_end_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && hs_cnt == depth_q - 1'b1) |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_arm_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POST && arm) |=> (state == ST_POST || state == ST_DONE));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !out_valid));
endmodule

bind trig_capture cap_chk #(.PW(PROBE_W), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .state(state_q), .arm(arm), .wr_en(wr_en),
    .wcnt(wcnt_q), .pre_q(pre_q), .depth_q(depth_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_trig_capture.sv
module test_trig_capture;
    localparam int PW = 8, AW = 5, CW = 8, MAXD = 1 << AW, NV = 10;

    // columns: mode, depth, position, trigger index, re-arm, busy write, skip config
    localparam int V_MODE[NV]  = '{0, 1, 2, 3, 2, 0, 2, 3, 2, 2};
    localparam int V_DEP[NV]   = '{8, 16, 0, 10, 50, 5, 8, 12, 8, 0};
    localparam int V_PCT[NV]   = '{50, 25, 90, 33, 120, 0, 50, 75, 50, 0};
    localparam int V_TK[NV]    = '{10, 40, 5, 0, 2, 3, 0, 20, 0, 0};
    localparam bit V_REARM[NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0};
    localparam bit V_POKE[NV]  = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam bit V_SKIP[NV]  = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

    logic clk = 0, rst = 1;
    logic cfg_we = 0, arm = 0, trig_in = 0, out_ready = 0, out_valid;
    logic [1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [PW-1:0] probe = '0, out_data;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    trig_capture #(.PROBE_W(PW), .ADDR_W(AW), .CFG_W(CW)) i_trig_capture (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .arm(arm), .probe(probe), .trig_in(trig_in), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_wr(int a, int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = CW'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic pat(int mode, int tk, int k);
        return (mode == 0 || mode == 2) ? (k >= tk) : (k < tk);
    endfunction

    task automatic run_case(int idx);
        int mode = V_MODE[idx], tk = V_TK[idx];
        int dc, p, post, pre, t, k;
        if (V_SKIP[idx]) begin
            mode = V_MODE[idx - 1]; dc = 8; p = 50;  // values still held from the previous case (R8)
        end else begin
            dc = (V_DEP[idx] == 0 || V_DEP[idx] > MAXD) ? MAXD : V_DEP[idx];  // R3
            p  = (V_PCT[idx] > 100) ? 100 : V_PCT[idx];
            cfg_wr(0, mode); cfg_wr(1, V_DEP[idx]); cfg_wr(2, V_PCT[idx]);
        end
        post = dc * (100 - p) / 100;                // R4
        if (post == 0) post = 1;
        pre = dc - post;
        t = (mode >= 2) ? ((tk > pre) ? tk : pre) : tk;  // R5 level modes wait for history
        @(negedge clk);
        arm = 1; trig_in = pat(mode, tk, -1);
        k = 0;
        forever begin
            @(negedge clk);
            if (out_valid || k > 400) break;
            arm       = V_REARM[idx] && (k == 2);
            cfg_we    = V_POKE[idx] && (k == 1);
            cfg_addr  = 2'd1; cfg_wdata = CW'(3);
            probe     = PW'(k);
            trig_in   = pat(mode, tk, k);
            k++;
        end
        arm = 0; cfg_we = 0;
        check(out_valid == 1, $sformatf("R2 case%0d capture done", idx), out_valid, 1);
        check(out_data == PW'(t - pre), $sformatf("R6 case%0d first sample", idx), out_data, t - pre);
        @(negedge clk);
        check(out_valid && out_data == PW'(t - pre), $sformatf("R7 case%0d stall hold", idx),
              out_data, t - pre);
        out_ready = 1;
        for (int i = 0; i < dc; i++) begin
            check(out_valid && out_data == PW'(t - pre + i),
                  $sformatf("R1 case%0d sample %0d", idx, i), out_data, (t - pre + i) % 256);
            @(negedge clk);
        end
        check(out_valid == 0, $sformatf("R6 case%0d length", idx), out_valid, 0);
        out_ready = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R9 reset idle", out_valid, 0);
        rst = 0;
        for (int v = 0; v < NV; v++) run_case(v);
        // R8: arm during read-out is ignored; R9: reset mid read-out returns to idle
        cfg_wr(0, 2); cfg_wr(1, 4); cfg_wr(2, 50);
        @(negedge clk); arm = 1; trig_in = 1;
        @(negedge clk); arm = 0;
        repeat (8) @(negedge clk);
        check(out_valid == 1, "R8 read-out reached", out_valid, 1);
        arm = 1;
        @(negedge clk); arm = 0;
        check(out_valid == 1, "R8 arm in read-out ignored", out_valid, 1);
        rst = 1;
        @(negedge clk);
        check(out_valid == 0, "R9 reset during read-out", out_valid, 0);
        rst = 0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule